// File: doc/BRIEF.md
# AES-128 Block Decryptor

This block turns one 128-bit AES ciphertext block back into plaintext with a single inverse round datapath that is reused once per clock. Ciphertext is written in as four 32-bit words into an input buffer. A start pulse moves the gathered block into the working state, XORed with the last round key. Ten rounds then follow, one per clock, and an end-of-conversion flag rises. The plaintext stays in the state register, and the host reads it out one 32-bit word at a time through a word-select multiplexer.

Round keys are not expanded here. The core presents a round index toward an external, precomputed key table and expects the matching 128-bit round key back in the same cycle, through a combinational lookup. The index walks from the last key down to key 0.

Top module: `aes_dec_core`

## Requirements
- R1: After reset, eoc_o is low and round_idx_o equals 10.
- R2: Each cycle with din_we_i high stores din_i into the next buffer word. Writes fill words 0, 1, 2, 3 and then wrap to word 0. Word 0 carries block bytes 0..3, with byte 0 in bits 31:24. Block byte k sits at row k mod 4, column k div 4 of the state.
- R3: While idle, round_idx_o is 10, and start XORs the buffered block with that key. During round n (n = 1..10), round_idx_o is 10 - n.
- R4: The FIPS-197 AES-128 example ciphertext 69c4e0d86a7b0430d8cdb78070b4c55a, with key 000102...0f, decrypts to 00112233445566778899aabbccddeeff.
- R5: For any key and plaintext, the standard AES-128 encryption of the plaintext decrypts back to that plaintext. Rounds 1..9 apply inverse row shift (row i rotated right by i), inverse byte substitution, key addition and inverse column mixing over GF(2^8) mod 0x11B. Round 10 omits the column mixing.
- R6: eoc_o rises exactly 10 clock edges after the edge that accepts start_i.
- R7: eoc_o stays high until the next start. The edge that accepts that start clears it.
- R8: A start_i pulse while a block is in progress is ignored. The round sequence, latency and result are unchanged.
- R9: Buffer writes during processing do not alter the block in progress. They prepare the next block.
- R10: While eoc_o is high, dout_o returns plaintext word word_sel_i, with word 0 holding bytes 0..3 in the same byte order as R2. It is stable while word_sel_i is stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin decrypting the buffered block (ignored when busy) |
| din_i | input | 32 | Ciphertext word |
| din_we_i | input | 1 | Word strobe for din_i |
| round_idx_o | output | 4 | Index of the round key requested from the key table |
| round_key_i | input | 128 | Round key for round_idx_o, same cycle |
| eoc_o | output | 1 | End of conversion, plaintext valid |
| word_sel_i | input | 2 | Plaintext word select |
| dout_o | output | 32 | Selected plaintext word |

## Verification
The hardest situations to reach are the ones that overlap with a running block: a second start arriving in mid-run, and the next ciphertext being written into the buffer while the current one is still being processed. The directed tasks inject both at chosen round positions inside the ten-cycle window. They then confirm that the round index keeps counting down, that eoc_o still rises on the tenth edge, and that the plaintext matches a reference encryption computed in the bench. A following run then uses the block written during the overlap.

// File: rtl/aes_dec_pkg.sv
package aes_dec_pkg;
  localparam int BLK_W   = 128;
  localparam int N_BYTES = BLK_W / 8;

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x, y;
    p = 8'h00;
    x = a;
    y = b;
    for (int i = 0; i < 8; i++) begin
      if (y[0]) p = p ^ x;
      x = x[7] ? ({x[6:0], 1'b0} ^ 8'h1b) : {x[6:0], 1'b0};
      y = {1'b0, y[7:1]};
    end
    return p;
  endfunction

  // x^254 = x^-1 in GF(2^8); 0 maps to 0
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r, p, e;
    r = 8'h01;
    p = a;
    e = 8'hfe;
    for (int i = 0; i < 8; i++) begin
      if (e[0]) r = gf_mul(r, p);
      p = gf_mul(p, p);
      e = {1'b0, e[7:1]};
    end
    return r;
  endfunction

  function automatic logic [7:0] inv_sbox(input logic [7:0] s);
    logic [7:0] b;
    b = {s[6:0], s[7]} ^ {s[4:0], s[7:5]} ^ {s[1:0], s[7:2]} ^ 8'h05;
    return gf_inv(b);
  endfunction
endpackage

// File: rtl/aes_dec_in_buf.sv
module aes_dec_in_buf #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 4,
  localparam int PTR_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        we_i,
  input  logic [WORD_W-1:0]           data_i,
  output logic [WORD_W*NUM_WORDS-1:0] blk_o
);
  logic [WORD_W-1:0] words_q [NUM_WORDS];
  logic [PTR_W-1:0]  ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      for (int i = 0; i < NUM_WORDS; i++) words_q[i] <= '0;
    end else if (we_i) begin
      words_q[ptr_q] <= data_i;
      ptr_q <= (ptr_q == PTR_W'(NUM_WORDS - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_pack
    assign blk_o[WORD_W*(NUM_WORDS-g)-1 -: WORD_W] = words_q[g];
  end
endmodule

// File: rtl/aes_dec_round.sv
module aes_dec_round
  import aes_dec_pkg::*;
(
  input  logic [BLK_W-1:0] st_i,
  input  logic [BLK_W-1:0] key_i,
  input  logic             last_i,
  output logic [BLK_W-1:0] st_o
);
  logic [7:0] in_b  [N_BYTES];
  logic [7:0] ak_b  [N_BYTES];
  logic [7:0] mix_b [N_BYTES];
  logic [BLK_W-1:0] ak_v, mix_v;

  for (genvar k = 0; k < N_BYTES; k++) begin : g_byte
    localparam int ROW = k % 4;
    localparam int COL = k / 4;
    localparam int SRC = 4 * ((COL - ROW + 4) % 4) + ROW; // row shifted right
    assign in_b[k] = st_i[BLK_W-1-8*k -: 8];
    assign ak_b[k] = inv_sbox(in_b[SRC]) ^ key_i[BLK_W-1-8*k -: 8];
    assign ak_v[BLK_W-1-8*k -: 8]  = ak_b[k];
    assign mix_v[BLK_W-1-8*k -: 8] = mix_b[k];
  end

  for (genvar c = 0; c < 4; c++) begin : g_col
    logic [7:0] a0, a1, a2, a3;
    assign a0 = ak_b[4*c];
    assign a1 = ak_b[4*c+1];
    assign a2 = ak_b[4*c+2];
    assign a3 = ak_b[4*c+3];
    assign mix_b[4*c]   = gf_mul(a0, 8'h0e) ^ gf_mul(a1, 8'h0b) ^ gf_mul(a2, 8'h0d) ^ gf_mul(a3, 8'h09);
    assign mix_b[4*c+1] = gf_mul(a0, 8'h09) ^ gf_mul(a1, 8'h0e) ^ gf_mul(a2, 8'h0b) ^ gf_mul(a3, 8'h0d);
    assign mix_b[4*c+2] = gf_mul(a0, 8'h0d) ^ gf_mul(a1, 8'h09) ^ gf_mul(a2, 8'h0e) ^ gf_mul(a3, 8'h0b);
    assign mix_b[4*c+3] = gf_mul(a0, 8'h0b) ^ gf_mul(a1, 8'h0d) ^ gf_mul(a2, 8'h09) ^ gf_mul(a3, 8'h0e);
  end

  assign st_o = last_i ? ak_v : mix_v;
endmodule

// File: rtl/aes_dec_ctrl.sv
module aes_dec_ctrl #(
  parameter int NUM_ROUNDS = 10,
  localparam int IDX_W     = $clog2(NUM_ROUNDS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             load_o,
  output logic             busy_o,
  output logic             last_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             eoc_o
);
  logic [IDX_W-1:0] rnd_q;
  logic             eoc_q;

  assign busy_o = (rnd_q != '0);
  assign load_o = start_i && !busy_o;
  assign last_o = (rnd_q == IDX_W'(NUM_ROUNDS));
  assign idx_o  = IDX_W'(NUM_ROUNDS) - rnd_q;
  assign eoc_o  = eoc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rnd_q <= '0;
      eoc_q <= 1'b0;
    end else if (load_o) begin
      rnd_q <= IDX_W'(1);
      eoc_q <= 1'b0;
    end else if (busy_o) begin
      if (last_o) begin
        rnd_q <= '0;
        eoc_q <= 1'b1;
      end else begin
        rnd_q <= rnd_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/aes_dec_core.sv
module aes_dec_core
  import aes_dec_pkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int NUM_ROUNDS = 10,
  localparam int NUM_WORDS = BLK_W / WORD_W,
  localparam int SEL_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int IDX_W     = $clog2(NUM_ROUNDS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] din_i,
  input  logic              din_we_i,
  output logic [IDX_W-1:0]  round_idx_o,
  input  logic [BLK_W-1:0]  round_key_i,
  output logic              eoc_o,
  input  logic [SEL_W-1:0]  word_sel_i,
  output logic [WORD_W-1:0] dout_o
);
  logic             load, busy, last;
  logic [BLK_W-1:0] buf_blk, st_q, st_nxt;
  logic [WORD_W-1:0] st_words [NUM_WORDS];

  aes_dec_in_buf #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) in_buf_i (
    .clk_i, .rst_ni, .we_i(din_we_i), .data_i(din_i), .blk_o(buf_blk)
  );

  aes_dec_ctrl #(.NUM_ROUNDS(NUM_ROUNDS)) ctrl_i (
    .clk_i, .rst_ni, .start_i, .load_o(load), .busy_o(busy), .last_o(last),
    .idx_o(round_idx_o), .eoc_o
  );

  aes_dec_round round_i (
    .st_i(st_q), .key_i(round_key_i), .last_i(last), .st_o(st_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   st_q <= '0;
    else if (load) st_q <= buf_blk ^ round_key_i;  // initial whitening, last key
    else if (busy) st_q <= st_nxt;
  end

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_out
    assign st_words[g] = st_q[WORD_W*(NUM_WORDS-g)-1 -: WORD_W];
  end
  assign dout_o = st_words[word_sel_i];
endmodule

// File: rtl/aes_dec_core_chk.sv
module aes_dec_core_chk #(
  parameter int NUM_ROUNDS = 10,
  parameter int IDX_W      = 4,
  parameter int SEL_W      = 2,
  parameter int WORD_W     = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_i,
  input logic              eoc_i,
  input logic [IDX_W-1:0]  idx_i,
  input logic [SEL_W-1:0]  sel_i,
  input logic [WORD_W-1:0] dout_i
);
  localparam int CNT_W = $clog2(NUM_ROUNDS + 2) + 1;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (start_i && !busy_i) cnt_q <= '0;
    else if (busy_i)             cnt_q <= cnt_q + 1'b1;
  end

  AST_IDLE_LAST_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> idx_i == IDX_W'(NUM_ROUNDS)); // R3
  AST_IDX_DESCEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && $past(busy_i) |-> idx_i == IDX_W'($past(idx_i) - 1'b1)); // R3
  AST_EOC_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(eoc_i) |-> cnt_q == CNT_W'(NUM_ROUNDS)); // R6
  AST_EOC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_i && !start_i |=> eoc_i); // R7
  AST_EOC_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_i && start_i |=> !eoc_i && busy_i); // R7
  AST_BUSY_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && start_i && idx_i != '0 |=> idx_i == IDX_W'($past(idx_i) - 1'b1)); // R8
  AST_DOUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_i && $past(eoc_i) && $stable(sel_i) |-> $stable(dout_i)); // R10
endmodule

bind aes_dec_core aes_dec_core_chk #(
  .NUM_ROUNDS(NUM_ROUNDS), .IDX_W(IDX_W), .SEL_W(SEL_W), .WORD_W(WORD_W)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_i(busy),
  .eoc_i(eoc_o), .idx_i(round_idx_o), .sel_i(word_sel_i), .dout_i(dout_o)
);

// File: tb/aes_dec_core_tb_top.sv
`timescale 1ns/1ps
module aes_dec_core_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [31:0]  din_i = '0;
  logic         din_we_i = 1'b0;
  logic [3:0]   round_idx_o;
  logic [127:0] round_key_i;
  logic         eoc_o;
  logic [1:0]   word_sel_i = '0;
  logic [31:0]  dout_o;

  logic [127:0] rk_tab [0:10];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;
  assign round_key_i = (round_idx_o <= 4'd10) ? rk_tab[round_idx_o] : '0;

  aes_dec_core dut_i (.*);

  function automatic logic [7:0] mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p = 0;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= a;
      a = a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
    end
    return p;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] inv = 0;
    for (int c = 1; c < 256; c++)
      if (mul(x, 8'(c)) == 8'h01) inv = 8'(c);
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^ {inv[4:0], inv[7:5]}
               ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

  task automatic expand_key(input logic [127:0] key);
    logic [31:0] w [44];
    logic [7:0]  rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      logic [31:0] t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {sbox(t[31:24]) ^ rc, sbox(t[23:16]), sbox(t[15:8]), sbox(t[7:0])};
        rc = mul(rc, 8'h02);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) rk_tab[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
  endtask

  function automatic logic [127:0] encrypt(input logic [127:0] pt);
    logic [127:0] s = pt ^ rk_tab[0];
    for (int r = 1; r <= 10; r++) begin
      logic [7:0] b [16];
      logic [7:0] n [16];
      for (int k = 0; k < 16; k++) b[k] = sbox(s[127-8*k -: 8]);
      for (int k = 0; k < 16; k++) n[k] = b[4*(((k/4) + (k%4)) % 4) + (k%4)];
      if (r < 10)
        for (int c = 0; c < 4; c++) begin
          logic [7:0] a0 = n[4*c], a1 = n[4*c+1], a2 = n[4*c+2], a3 = n[4*c+3];
          n[4*c]   = mul(a0, 2) ^ mul(a1, 3) ^ a2 ^ a3;
          n[4*c+1] = a0 ^ mul(a1, 2) ^ mul(a2, 3) ^ a3;
          n[4*c+2] = a0 ^ a1 ^ mul(a2, 2) ^ mul(a3, 3);
          n[4*c+3] = mul(a0, 3) ^ a1 ^ a2 ^ mul(a3, 2);
        end
      for (int k = 0; k < 16; k++) s[127-8*k -: 8] = n[k];
      s = s ^ rk_tab[r];
    end
    return s;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_block(input logic [127:0] blk);
    for (int i = 0; i < 4; i++) begin
      din_i = blk[127-32*i -: 32];
      din_we_i = 1'b1;
      @(negedge clk_i);
    end
    din_we_i = 1'b0;
  endtask

  // start at a negedge; optional mid-run start (R8) and mid-run buffer load (R9)
  task automatic run_block(input string tag, input logic [127:0] exp_pt,
                           input bit spurious, input bit preload, input logic [127:0] next_ct);
    logic [127:0] got;
    bit idx_ok = 1, eoc_ok = 1;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    check({tag, " R7 eoc cleared by start"}, eoc_o, 0);
    for (int r = 1; r <= 10; r++) begin
      if (round_idx_o !== 4'(10 - r)) idx_ok = 0;
      if (eoc_o !== 1'b0) eoc_ok = 0;
      start_i = spurious && (r == 4 || r == 9);
      if (preload && r >= 2 && r <= 5) begin
        din_i = next_ct[127-32*(r-2) -: 32];
        din_we_i = 1'b1;
      end else din_we_i = 1'b0;
      @(negedge clk_i);
    end
    start_i = 1'b0;
    din_we_i = 1'b0;
    check({tag, " R3 round index 9..0"}, idx_ok, 1);
    check({tag, " R6 eoc low during rounds"}, eoc_ok, 1);
    check({tag, " R6 eoc after 10 edges"}, eoc_o, 1);
    check({tag, " R3 idle index"}, round_idx_o, 10);
    for (int w = 0; w < 4; w++) begin
      word_sel_i = 2'(w);
      #1;
      got[127-32*w -: 32] = dout_o;
    end
    check({tag, " R10 plaintext words"}, got, exp_pt);
    repeat (3) @(negedge clk_i);
    check({tag, " R7 eoc held"}, eoc_o, 1);
    word_sel_i = 2'd2;
    #1;
    check({tag, " R10 word 2 held"}, dout_o, exp_pt[63:32]);
  endtask

  task automatic t_reset;
    check("R1 eoc after reset", eoc_o, 0);
    check("R1 index after reset", round_idx_o, 10);
  endtask

  task automatic t_fips;
    expand_key(128'h000102030405060708090a0b0c0d0e0f);
    check("R4 bench reference", encrypt(128'h00112233445566778899aabbccddeeff),
          128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    write_block(128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    run_block("R4 fips", 128'h00112233445566778899aabbccddeeff, 0, 0, '0);
  endtask

  task automatic t_wrap;
    logic [127:0] pt = 128'hdeadbeef_01234567_89abcdef_a5a55a5a;
    write_block(128'hffffffff_eeeeeeee_dddddddd_cccccccc);  // overwritten after wrap
    write_block(encrypt(pt));
    run_block("R2 wrap", pt, 0, 0, '0);
  endtask

  task automatic t_random;
    for (int v = 0; v < 4; v++) begin
      logic [127:0] key = {$urandom, $urandom, $urandom, $urandom};
      logic [127:0] pt  = {$urandom, $urandom, $urandom, $urandom};
      if (v == 0) begin key = '0; pt = '0; end
      if (v == 1) begin key = '1; pt = '1; end
      expand_key(key);
      write_block(encrypt(pt));
      run_block("R5 random", pt, 0, 0, '0);
    end
  endtask

  task automatic t_overlap;
    logic [127:0] pt_a = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
    logic [127:0] pt_b = 128'h11111111_22222222_33333333_44444444;
    expand_key(128'h2b7e151628aed2a6abf7158809cf4f3c);
    write_block(encrypt(pt_a));
    run_block("R8 R9 overlap", pt_a, 1, 1, encrypt(pt_b));
    run_block("R9 next block", pt_b, 0, 0, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_fips();
    t_wrap();
    t_random();
    t_overlap();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule